// File: doc/BRIEF.md
# Presettable Binary Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter, eight bits wide by default, that can be preset from a parallel data word. An active-low flag marks the all-ones state. Because that flag comes straight from the registered count, it can drive the count enable of the next stage when counters are chained.

A reload select input turns the counter into a programmable divider. When the select is low, the counter runs freely and wraps from all ones to zero. When the select is high, reaching all ones makes the next enabled edge reload the preset word instead of wrapping. The output then repeats with a period of (2^WIDTH - preset) enabled clocks. A separate parallel-load input gives an explicit preset at any time. An asynchronous master reset clears the count.

Top module: `preset_counter`

## Requirements
- R1: While `mreset` is high, `count_q` is zero and `tc_n` is 1, with no clock edge needed.
- R2: `tc_n` is 0 exactly when every bit of `count_q` is 1, and is 1 otherwise.
- R3: With `load_en` low and `cnt_en_n` high, a rising edge leaves `count_q` unchanged.
- R4: With `load_en` low, `cnt_en_n` low and `reload_sel` low, a rising edge adds one to `count_q`, wrapping from all ones to zero.
- R5: With `load_en` low, `cnt_en_n` low, `reload_sel` high and `count_q` all ones, a rising edge loads `preset_in` into `count_q`.
- R6: With `load_en` high, a rising edge loads `preset_in`, whatever the levels of `cnt_en_n`, `reload_sel` and the count. This load has the highest priority below reset.
- R7: `reload_sel` high has no effect while `count_q` is not all ones: the counter increments as in R4.
- R8: With `reload_sel` high and `count_q` all ones, `cnt_en_n` high with `load_en` low holds the count; the reload happens only when counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| mreset | input | 1 | Asynchronous master reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| load_en | input | 1 | Synchronous parallel load, active high |
| reload_sel | input | 1 | 1 = reload on terminal count, 0 = free running |
| preset_in | input | WIDTH | Preset word |
| count_q | output | WIDTH | Current count |
| tc_n | output | 1 | Terminal count, active low, all-ones state |

## Verification
A wrong next-state choice appears on `count_q` one edge after the stimulus. Examples are an increment taken while disabled, a wrap taken where a reload was due, or a load losing priority. The bench's model compares the count and `tc_n` after every edge, so such a fault is reported in that same cycle. A wrong terminal-count decode shows at once on `tc_n`. In reload mode it also shows one edge later as a missing or spurious reload on `count_q`.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_INC    = 2'd1,
        ACT_PRESET = 2'd2,
        ACT_RELOAD = 2'd3
    } cnt_action_e;
endpackage

// File: rtl/cnt_tc_detect.sv
module cnt_tc_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count_i,
    output logic             tc_n_o
);
    always_comb begin
        tc_n_o = ~(&count_i);
    end
endmodule

// File: rtl/cnt_action_sel.sv
module cnt_action_sel
    import preset_counter_pkg::*;
(
    input  logic        cnt_en_n_i,
    input  logic        load_en_i,
    input  logic        reload_sel_i,
    input  logic        tc_n_i,
    output cnt_action_e action_o
);
    always_comb begin
        if (load_en_i) begin
            action_o = ACT_PRESET;
        end else if (cnt_en_n_i) begin
            action_o = ACT_HOLD;
        end else if (reload_sel_i && !tc_n_i) begin
            action_o = ACT_RELOAD;
        end else begin
            action_o = ACT_INC;
        end
    end
endmodule

// File: rtl/preset_counter.sv
module preset_counter
    import preset_counter_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             mreset,
    input  logic             cnt_en_n,
    input  logic             load_en,
    input  logic             reload_sel,
    input  logic [WIDTH-1:0] preset_in,
    output logic [WIDTH-1:0] count_q,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_state_t;

    cnt_state_t  state_d;
    cnt_state_t  state_q;
    cnt_action_e action;

    cnt_tc_detect #(.WIDTH(WIDTH)) i_tc_detect (
        .count_i (state_q.count),
        .tc_n_o  (tc_n)
    );

    cnt_action_sel i_action_sel (
        .cnt_en_n_i   (cnt_en_n),
        .load_en_i    (load_en),
        .reload_sel_i (reload_sel),
        .tc_n_i       (tc_n),
        .action_o     (action)
    );

    always_comb begin
        state_d = state_q;
        unique case (action)
            ACT_PRESET: state_d.count = preset_in;
            ACT_RELOAD: state_d.count = preset_in;
            ACT_INC:    state_d.count = state_q.count + ONE;
            default:    state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk or posedge mreset) begin
        if (mreset) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_q = state_q.count;
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             mreset,
    input logic             cnt_en_n,
    input logic             load_en,
    input logic             reload_sel,
    input logic [WIDTH-1:0] preset_in,
    input logic [WIDTH-1:0] count_q,
    input logic             tc_n
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    // R1: reset holds count at zero
    always @(negedge clk) begin
        if (mreset) begin
            assert_reset_clear_R1: assert (count_q == '0 && tc_n == 1'b1);
        end
    end

    assert_tc_decode_R2: assert property (@(posedge clk) disable iff (mreset)
        (tc_n == 1'b0) == (count_q == ALL_ONES));

    assert_hold_R3: assert property (@(posedge clk) disable iff (mreset)
        (!load_en && cnt_en_n) |=> $stable(count_q));

    assert_inc_R4: assert property (@(posedge clk) disable iff (mreset)
        (!load_en && !cnt_en_n && !reload_sel) |=> count_q == $past(count_q) + WIDTH'(1));

    assert_reload_R5: assert property (@(posedge clk) disable iff (mreset)
        (!load_en && !cnt_en_n && reload_sel && count_q == ALL_ONES) |=> count_q == $past(preset_in));

    assert_preset_R6: assert property (@(posedge clk) disable iff (mreset)
        load_en |=> count_q == $past(preset_in));

    assert_sel_inert_R7: assert property (@(posedge clk) disable iff (mreset)
        (!load_en && !cnt_en_n && reload_sel && count_q != ALL_ONES) |=> count_q == $past(count_q) + WIDTH'(1));
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .mreset     (mreset),
    .cnt_en_n   (cnt_en_n),
    .load_en    (load_en),
    .reload_sel (reload_sel),
    .preset_in  (preset_in),
    .count_q    (count_q),
    .tc_n       (tc_n)
);

// File: tb/test_preset_counter.sv
`timescale 1ns/1ps
module test_preset_counter;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         mreset = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         load_en = 1'b0;
    logic         reload_sel = 1'b0;
    logic [W-1:0] preset_in = '0;
    logic [W-1:0] count_q;
    logic         tc_n;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    preset_counter #(.WIDTH(W)) i_preset_counter (
        .clk(clk), .mreset(mreset), .cnt_en_n(cnt_en_n), .load_en(load_en),
        .reload_sel(reload_sel), .preset_in(preset_in), .count_q(count_q), .tc_n(tc_n)
    );

    task automatic compare(input string req);
        logic exp_tc;
        exp_tc = (ref_cnt == 255) ? 1'b0 : 1'b1;
        checks++;
        if (count_q !== W'(ref_cnt)) begin
            errors++;
            $display("FAIL %s count actual=%0d expected=%0d", req, count_q, ref_cnt);
        end
        checks++;
        if (tc_n !== exp_tc) begin
            errors++;
            $display("FAIL R2 (%s) tc_n actual=%b expected=%b", req, tc_n, exp_tc);
        end
    endtask

    // one clock: apply inputs, update reference at the edge, check at the falling edge
    task automatic cyc(input bit en_n, input bit ld, input bit sel,
                       input int p, input string req);
        cnt_en_n   = en_n;
        load_en    = ld;
        reload_sel = sel;
        preset_in  = W'(p);
        @(posedge clk);
        if (ld) ref_cnt = p;
        else if (!en_n) begin
            if (sel && ref_cnt == 255) ref_cnt = p;
            else ref_cnt = (ref_cnt + 1) % 256;
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        compare("R1 reset");
        @(negedge clk);
        mreset = 1'b0;
        @(negedge clk);
        compare("R1 after release");

        cyc(1, 0, 0, 8'h55, "R3 hold");
        cyc(1, 0, 1, 8'h55, "R3 hold sel");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, "R4 increment");
        cyc(1, 1, 0, 8'hFA, "R6 load while disabled");
        for (int i = 0; i < 8; i++) cyc(0, 0, 0, 8'h11, "R4 wrap");
        cyc(0, 1, 1, 8'hF0, "R6 load preset F0");
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 8'hF0, "R5 divider");
        cyc(0, 1, 0, 8'hFE, "R6 load FE");
        cyc(0, 0, 1, 8'h20, "R7 sel inert");
        cyc(1, 0, 1, 8'h20, "R8 hold at tc");
        cyc(1, 0, 1, 8'h20, "R8 hold at tc");
        cyc(0, 0, 1, 8'h20, "R5 reload 20");
        cyc(0, 0, 1, 8'h20, "R7 increment after reload");
        cyc(0, 1, 0, 8'hFF, "R6 load FF");
        cyc(0, 1, 1, 8'h33, "R6 load beats reload");
        cyc(0, 1, 0, 8'hFF, "R6 load FF");
        cyc(0, 0, 0, 8'h77, "R4 wrap sel low");

        for (int i = 0; i < 20; i++) cyc(i % 3 == 0, i % 7 == 0, i % 2 == 0, 250 + i % 5, "R4 R5 mixed");

        #3;
        mreset = 1'b1;
        ref_cnt = 0;
        #2;
        compare("R1 async reset mid-cycle");
        @(negedge clk);
        compare("R1 reset held");
        mreset = 1'b0;
        cyc(0, 0, 0, 0, "R4 after reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule